// File: doc/BRIEF.md
# Current-Chop Sense Blanking Timer

This block sits between the over-current trip comparator of one H-bridge and the chopping logic that ends the drive phase. Each time the bridge starts driving current, and each time the controller switches into fast decay, the block opens a blanking window. While the window runs, it discards the trip input completely. This hides the switching spike that follows a bridge transition. Because no trip can get through until the window closes, the same window also sets the shortest drive phase the PWM can produce.

The block runs on a 50 MHz clock, so one count is 20 ns. The window lasts 25 cycles plus the blanking code, and the code saturates at 232. This gives a range of 500 ns to 5.14 µs in 20 ns steps. The raw trip level passes through a two-flop synchronizer. After that, the block turns a trip level that is visible outside blanking into a single one-clock qualified trip pulse.

Top module: `chop_blank_timer`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `blanking_o` and `trip_pulse_o` are both 0.
- R2: A drive-start strobe sampled at a rising edge raises `blanking_o` in the next cycle. `blanking_o` then stays high for exactly 25 + code cycles, counted from that cycle.
- R3: A fast-decay-start strobe re-arms the same window, with the same length and timing as R2.
- R4: Code values above 232 act as 232, so the longest window is 257 cycles. Code 232 and code 255 give the same length.
- R5: The code is captured on the edge that samples the strobe. Changing the code while the window runs has no effect on that window's length.
- R6: A strobe that arrives while a window is running restarts the count. The window then ends 25 + code cycles after the cycle that follows the new strobe.
- R7: While `blanking_o` is high, `trip_pulse_o` stays 0. A trip that rises and falls entirely inside the window gives no pulse after the window ends.
- R8: A synchronized trip that is still high when blanking ends gives a pulse in the first cycle in which `blanking_o` is 0.
- R9: When the bridge is unblanked, a raw trip that goes high before edge n gives its pulse in the cycle after edge n+1. This is the two-flop synchronizer delay.
- R10: A pulse lasts exactly one cycle, however long the trip stays high. A further pulse needs the trip to fall and rise again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz clock |
| rst_n | input | 1 | Synchronous active-low reset |
| drive_start_i | input | 1 | One-cycle strobe: the bridge begins driving current |
| fast_start_i | input | 1 | One-cycle strobe: the controller enters fast decay |
| trip_raw_i | input | 1 | Comparator trip level, not yet synchronized |
| blank_code_i | input | CODE_W (8) | Blanking code, in 20 ns steps above the 25-cycle base |
| trip_pulse_o | output | 1 | Qualified trip, one cycle wide |
| blanking_o | output | 1 | High while the blanking window runs |

## Verification
The assertions assume the two strobes are single-cycle pulses sampled on the clock. They also assume the trip level is free to change at any time, so each assertion states its relation against what was sampled two edges earlier. The window-length checks assume the code stays at or below the width the counter is sized for. The stimulus changes every input only on the falling clock edge. It holds each strobe for exactly one cycle and moves the code only after the sampling edge. It raises and drops the trip both inside and outside windows, so that the discard, carry-over and restart cases each occur.

// File: rtl/cbt_pkg.sv
// Shared constants and helpers for the chop blanking timer.
// Assumes a 50 MHz clock, so one count is 20 ns.
package cbt_pkg;
    localparam int unsigned BLANK_BASE_DEF = 25;   // 500 ns floor
    localparam int unsigned BLANK_SAT_DEF  = 232;  // code ceiling
    localparam int unsigned CODE_W_DEF     = 8;
    localparam int unsigned SYNC_DEF       = 2;

    // Window length in cycles for a given code, after saturation.
    function automatic int unsigned win_cycles(input int unsigned code,
                                               input int unsigned base,
                                               input int unsigned sat);
        return base + ((code > sat) ? sat : code);
    endfunction
endpackage

// File: rtl/cbt_sync.sv
// Multi-flop synchronizer for the comparator trip level.
// Assumes STAGES >= 1. The output lags the input by STAGES edges.
module cbt_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_q;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) begin
                sh_q[i] <= sh_q[i-1];
            end
        end
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/cbt_window.sv
// Blanking window counter. When arm_i is sampled, the module captures
// the saturated code and runs for BASE + code cycles. A new arm_i
// restarts the count. Assumes CNT_W can hold BASE + SAT - 1.
module cbt_window #(
    parameter int unsigned CODE_W = 8,
    parameter int unsigned BASE   = 25,
    parameter int unsigned SAT    = 232,
    parameter int unsigned CNT_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              active_o
);
    logic [CODE_W-1:0] code_sat;
    logic [CNT_W-1:0]  last_idx;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  lim_q;
    logic              act_q;

    // Clamp the code and form the index of the last blanked cycle.
    always_comb begin
        code_sat = (code_i > CODE_W'(SAT)) ? CODE_W'(SAT) : code_i;
        last_idx = CNT_W'(BASE - 1) + CNT_W'(code_sat);
    end

    // Arm, count and expire the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            cnt_q <= '0;
            lim_q <= '0;
        end else if (arm_i) begin
            act_q <= 1'b1;
            cnt_q <= '0;
            lim_q <= last_idx;
        end else if (act_q) begin
            if (cnt_q == lim_q) begin
                act_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign active_o = act_q;
endmodule

// File: rtl/cbt_qualify.sv
// Trip qualifier. Passes the synchronized trip only when no window is
// running, and turns each unblanked high stretch into one pulse.
// Assumes trip_i is already synchronous to clk.
module cbt_qualify (
    input  logic clk,
    input  logic rst_n,
    input  logic trip_i,
    input  logic blank_i,
    output logic pulse_o
);
    logic live;
    logic live_q;

    // Trip is visible only outside the window.
    assign live = trip_i && !blank_i;

    // Remember last cycle's visibility so that only its start gives a pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= 1'b0;
        end else begin
            live_q <= live;
        end
    end

    assign pulse_o = live && !live_q;
endmodule

// File: rtl/chop_blank_timer.sv
// Sense blanking timer for one H-bridge chopping channel. Either start
// strobe arms the window. The window masks the trip and sets the minimum
// drive time. Assumes a 50 MHz clock and single-cycle strobes.
module chop_blank_timer #(
    parameter int unsigned CODE_W      = cbt_pkg::CODE_W_DEF,
    parameter int unsigned BASE_CYCLES = cbt_pkg::BLANK_BASE_DEF,
    parameter int unsigned CODE_SAT    = cbt_pkg::BLANK_SAT_DEF,
    parameter int unsigned SYNC_STAGES = cbt_pkg::SYNC_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              drive_start_i,
    input  logic              fast_start_i,
    input  logic              trip_raw_i,
    input  logic [CODE_W-1:0] blank_code_i,
    output logic              trip_pulse_o,
    output logic              blanking_o
);
    localparam int unsigned WIN_MIN = cbt_pkg::win_cycles(0, BASE_CYCLES, CODE_SAT);
    localparam int unsigned WIN_MAX = cbt_pkg::win_cycles(CODE_SAT, BASE_CYCLES, CODE_SAT);
    localparam int unsigned CNT_W   = $clog2(WIN_MAX);

    logic arm;
    logic trip_s;
    logic blank;

    // Either start event re-arms the same window.
    assign arm = drive_start_i || fast_start_i;

    cbt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (trip_raw_i),
        .q_o   (trip_s)
    );

    cbt_window #(
        .CODE_W (CODE_W),
        .BASE   (BASE_CYCLES),
        .SAT    (CODE_SAT),
        .CNT_W  (CNT_W)
    ) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_i    (arm),
        .code_i   (blank_code_i),
        .active_o (blank)
    );

    cbt_qualify u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .trip_i  (trip_s),
        .blank_i (blank),
        .pulse_o (trip_pulse_o)
    );

    assign blanking_o = blank;
endmodule

// File: rtl/chop_blank_checker.sv
// Property checker for chop_blank_timer, attached through bind.
// It watches only the ports. Window lengths are measured with a counter.
module chop_blank_checker #(
    parameter int unsigned MIN_WIN = 25,
    parameter int unsigned MAX_WIN = 257,
    parameter int unsigned SYNC_N  = 2
) (
    input logic clk,
    input logic rst_n,
    input logic drive_start_i,
    input logic fast_start_i,
    input logic trip_raw_i,
    input logic trip_pulse_o,
    input logic blanking_o
);
    localparam int unsigned RUN_W = $clog2(MAX_WIN + 2) + 1;

    logic [RUN_W-1:0] run_q;

    // Count the high cycles of the current window, restarting on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (drive_start_i || fast_start_i) begin
            run_q <= RUN_W'(1);
        end else if (blanking_o) begin
            run_q <= run_q + 1'b1;
        end
    end

    assert_drive_blanks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        drive_start_i |=> blanking_o);

    assert_fast_blanks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fast_start_i |=> blanking_o);

    assert_window_bounds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(blanking_o) |-> (run_q >= RUN_W'(MIN_WIN + 1)) && (run_q <= RUN_W'(MAX_WIN + 1)));

    assert_no_end_after_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_start_i || fast_start_i) |=> !$fell(blanking_o));

    assert_pulse_unblanked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trip_pulse_o |-> !blanking_o);

    assert_pulse_from_raw_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trip_pulse_o |-> $past(trip_raw_i, SYNC_N));

    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        trip_pulse_o |=> !trip_pulse_o);
endmodule

bind chop_blank_timer chop_blank_checker #(
    .MIN_WIN (WIN_MIN),
    .MAX_WIN (WIN_MAX),
    .SYNC_N  (SYNC_STAGES)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .drive_start_i (drive_start_i),
    .fast_start_i  (fast_start_i),
    .trip_raw_i    (trip_raw_i),
    .trip_pulse_o  (trip_pulse_o),
    .blanking_o    (blanking_o)
);

// File: tb/chop_blank_timer_tb.sv
// Scoreboard bench: the stimulus pushes the outputs expected in each cycle,
// and a falling-edge monitor pops and compares them.
module chop_blank_timer_tb;
    localparam time CLK_PERIOD = 20ns;

    typedef struct {
        int    cyc;
        int    b;      // expected blanking, -1 = don't care
        int    p;      // expected pulse, -1 = don't care
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       drive_start_i = 1'b0;
    logic       fast_start_i = 1'b0;
    logic       trip_raw_i = 1'b0;
    logic [7:0] blank_code_i = 8'd0;
    logic       trip_pulse_o;
    logic       blanking_o;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    chop_blank_timer u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .drive_start_i (drive_start_i),
        .fast_start_i  (fast_start_i),
        .trip_raw_i    (trip_raw_i),
        .blank_code_i  (blank_code_i),
        .trip_pulse_o  (trip_pulse_o),
        .blanking_o    (blanking_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int win(input int code);
        return 25 + ((code > 232) ? 232 : code);
    endfunction

    function automatic void want(input int c, input int b, input int p, input string tag);
        exp_t e;
        e.cyc = c; e.b = b; e.p = p; e.tag = tag;
        sb.push_back(e);
    endfunction

    // Monitor: compare every item that falls due in this cycle.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].cyc <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            if (e.cyc < cyc) begin
                checks++; errors++;
                $display("FAIL %s: item for cycle %0d missed (now %0d)", e.tag, e.cyc, cyc);
            end else begin
                if (e.b >= 0) begin
                    checks++;
                    if (int'(blanking_o) != e.b) begin
                        errors++;
                        $display("FAIL %s: cycle %0d blanking_o=%0d expected %0d", e.tag, cyc, blanking_o, e.b);
                    end
                end
                if (e.p >= 0) begin
                    checks++;
                    if (int'(trip_pulse_o) != e.p) begin
                        errors++;
                        $display("FAIL %s: cycle %0d trip_pulse_o=%0d expected %0d", e.tag, cyc, trip_pulse_o, e.p);
                    end
                end
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fire(input bit fast);
        if (fast) fast_start_i = 1'b1; else drive_start_i = 1'b1;
        step(1);
        fast_start_i = 1'b0;
        drive_start_i = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int s;
        int s2;
        int t;
        step(4);
        // R1: outputs quiet under reset and right after release
        want(cyc + 1, 0, 0, "R1");
        rst_n = 1'b1;
        want(cyc + 2, 0, 0, "R1");
        step(4);

        // R2: drive start, minimum code
        blank_code_i = 8'd0; s = cyc;
        want(s + 1, 1, 0, "R2"); want(s + 25, 1, 0, "R2"); want(s + 26, 0, 0, "R2");
        fire(0); step(30);

        // R3: fast-decay start re-arms the same window
        blank_code_i = 8'd10; s = cyc;
        want(s + 1, 1, 0, "R3"); want(s + win(10), 1, 0, "R3"); want(s + win(10) + 1, 0, 0, "R3");
        fire(1); step(40);

        // R4: code above the ceiling saturates
        blank_code_i = 8'd255; s = cyc;
        want(s + 257, 1, 0, "R4"); want(s + 258, 0, 0, "R4");
        fire(0); step(262);
        blank_code_i = 8'd232; s = cyc;
        want(s + 257, 1, 0, "R4"); want(s + 258, 0, 0, "R4");
        fire(1); step(262);

        // R5: code change mid-window ignored
        blank_code_i = 8'd5; s = cyc;
        want(s + 30, 1, 0, "R5"); want(s + 31, 0, 0, "R5");
        fire(0);
        blank_code_i = 8'd200;
        step(35);

        // R6: restart on a strobe within the window
        blank_code_i = 8'd0; s = cyc;
        want(s + 1, 1, 0, "R6");
        fire(0); step(9);
        s2 = cyc;
        want(s + 26, 1, 0, "R6"); want(s2 + 25, 1, 0, "R6"); want(s2 + 26, 0, 0, "R6");
        fire(0); step(30);

        // R7/R8: trip held through the window, pulse on first free cycle
        s = cyc; trip_raw_i = 1'b1;
        want(s + 10, 1, 0, "R7"); want(s + 25, 1, 0, "R8");
        want(s + 26, 0, 1, "R8"); want(s + 27, 0, 0, "R8");
        fire(0); step(30);
        trip_raw_i = 1'b0; step(5);

        // R7: trip that rises and falls inside the window is discarded
        blank_code_i = 8'd20; s = cyc;
        want(s + 46, 0, 0, "R7"); want(s + 47, 0, 0, "R7"); want(s + 48, 0, 0, "R7");
        fire(0); step(4);
        trip_raw_i = 1'b1; step(10);
        trip_raw_i = 1'b0; step(40);

        // R9/R10: unblanked latency, single pulse, re-trigger needs a fall
        t = cyc;
        want(t + 1, 0, 0, "R9"); want(t + 2, 0, 1, "R9");
        want(t + 3, 0, 0, "R10"); want(t + 5, 0, 0, "R10");
        trip_raw_i = 1'b1; step(6);
        trip_raw_i = 1'b0;
        want(t + 11, 0, 1, "R10"); want(t + 12, 0, 0, "R10");
        step(3);
        trip_raw_i = 1'b1; step(5);

        // R3/R8: fast decay masks a held trip, which returns after the window
        blank_code_i = 8'd3; s = cyc;
        want(s + 1, 1, 0, "R3"); want(s + 28, 1, 0, "R3");
        want(s + 29, 0, 1, "R8"); want(s + 30, 0, 0, "R8");
        fire(1); step(32);
        trip_raw_i = 1'b0; step(5);

        if (sb.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule